// File: doc/BRIEF.md
# Multicycle Memory-Operand Accumulator Core

This block is a small 16-bit processor core that runs a fixed fetch-execute sequence with no end. It owns a single word-addressed memory port. Each instruction is one 16-bit word. The top four bits pick the operation and the next two bits pick one of four general registers. The low ten bits hold the absolute word address of the second operand. Four operations are defined: copy a memory word into a register, copy a register into memory, add a memory word to a register, and subtract a memory word from a register. The chosen register is both the source and the destination.

Every instruction steps through the same phases: fetch, program-counter increment, decode, operand fetch, execute and write-back. Add, subtract and load first capture their operands in two ALU input latches. The result then passes through an ALU output latch on its way back to the register. The memory is synchronous with a fixed read latency of one cycle. The core therefore holds each read address for one wait cycle before it samples the data. The port has no back-pressure: memory must return read data exactly one cycle after the address and must accept a write in the cycle the write enable is high. A one-cycle retire strobe marks the end of each instruction.

Top module: `mcpu16_core`

## Requirements
- R1: While reset is low and in the first cycle after it, `mem_addr` equals the START_ADDR parameter (default 000h), `mem_we` is 0 and `retire` is 0. All four registers read as 0000h after reset.
- R2: The instruction fields are as follows. Bits 15..12 are the opcode (0001 load, 0010 store, 0011 add, 0100 subtract). Bits 11..10 select register 0..3. Bits 9..0 are the operand word address.
- R3: A load, add or subtract takes 8 cycles and any other opcode takes 5. `mem_addr` shows the PC for the first three cycles and PC+1 in the fourth. In the remaining cycles it shows the operand address.
- R4: Load writes mem[addr] into the selected register.
- R5: Store raises `mem_we` for exactly one cycle, which is the instruction's last cycle. In that cycle `mem_addr` is the operand address and `mem_wdata` is the selected register.
- R6: Add sets reg = reg + mem[addr] modulo 2^16 (7FFFh + 1 gives 8000h).
- R7: Subtract sets reg = reg - mem[addr] modulo 2^16 (0000h - 1 gives FFFFh).
- R8: Opcodes 0000 and 0101..1111 change no register and write no memory.
- R9: The PC advances by one for each instruction and wraps from 3FFh to 000h. After the three-instruction program at 080h, the next fetch is at 083h.
- R10: `retire` is high for exactly one cycle, the last cycle of each instruction.
- R11: Read data is sampled one cycle after its address is driven. A word stored by one instruction is seen by the fetch that follows it.
- R12: Each of the four registers keeps its own value, and store and add/subtract act only on the selected register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 10 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 16 | Memory read data, valid one cycle after its address |
| retire | output | 1 | One-cycle pulse at the end of each instruction |

## Verification
A store's write-back falls in the same cycle as the instruction's retire. The fetch of the next instruction follows on the very next cycle. The bench provokes the worst case with a store whose target is the word right after it. The overwritten word decodes as a new store, so the fetch must return the freshly written value and not the stale one. The cycle-by-cycle reference model predicts the bus trace for the rewritten instruction. The bench also checks the value that this instruction's own store leaves in memory.

// File: rtl/mcpu16_pkg.sv
package mcpu16_pkg;

  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OPC_LOAD  = 4'b0001;
  localparam logic [OPC_W-1:0] OPC_STORE = 4'b0010;
  localparam logic [OPC_W-1:0] OPC_ADD   = 4'b0011;
  localparam logic [OPC_W-1:0] OPC_SUB   = 4'b0100;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_FWAIT,
    ST_INCPC,
    ST_DECODE,
    ST_OPADDR,
    ST_OPWAIT,
    ST_EXEC,
    ST_WB
  } state_t;

  typedef enum logic [1:0] {
    ALU_PASS,
    ALU_ADD,
    ALU_SUB
  } alu_op_t;

endpackage

// File: rtl/mcpu16_alu.sv
module mcpu16_alu
  import mcpu16_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lat_load,
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] b_in,
  input  logic              alu_load,
  input  alu_op_t           op,
  output logic [DATA_W-1:0] out_q
);

  logic [DATA_W-1:0] in_a_q;
  logic [DATA_W-1:0] in_b_q;
  logic [DATA_W-1:0] result;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_a_q <= '0;
      in_b_q <= '0;
    end else if (lat_load) begin
      in_a_q <= a_in;
      in_b_q <= b_in;
    end
  end

  always_comb begin
    case (op)
      ALU_ADD: result = in_a_q + in_b_q;
      ALU_SUB: result = in_a_q - in_b_q;
      default: result = in_b_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else if (alu_load) out_q <= result;
  end

endmodule

// File: rtl/mcpu16_regfile.sv
module mcpu16_regfile #(
  parameter int NREG   = 4,
  parameter int DATA_W = 16,
  parameter int SEL_W  = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SEL_W-1:0]  wsel,
  input  logic [DATA_W-1:0] wdata,
  input  logic [SEL_W-1:0]  rsel,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs_q[g] <= '0;
      else if (we && (wsel == SEL_W'(g))) regs_q[g] <= wdata;
    end
  end

  assign rdata = regs_q[rsel];

endmodule

// File: rtl/mcpu16_ctrl.sv
module mcpu16_ctrl
  import mcpu16_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPC_W-1:0] opcode,
  output logic             ir_load,
  output logic             pc_inc,
  output logic             lat_load,
  output logic             alu_load,
  output logic             rf_we,
  output logic             mem_we,
  output logic             use_op_addr,
  output logic             retire,
  output alu_op_t          alu_op
);

  state_t state_q;
  state_t state_d;
  logic   is_rd;
  logic   is_st;

  always_comb begin
    is_rd = (opcode == OPC_LOAD) || (opcode == OPC_ADD) || (opcode == OPC_SUB);
    is_st = (opcode == OPC_STORE);
    case (opcode)
      OPC_ADD: alu_op = ALU_ADD;
      OPC_SUB: alu_op = ALU_SUB;
      default: alu_op = ALU_PASS;
    endcase
  end

  always_comb begin
    case (state_q)
      ST_FETCH:  state_d = ST_FWAIT;
      ST_FWAIT:  state_d = ST_INCPC;
      ST_INCPC:  state_d = ST_DECODE;
      ST_DECODE: state_d = is_rd ? ST_OPADDR : ST_WB;
      ST_OPADDR: state_d = ST_OPWAIT;
      ST_OPWAIT: state_d = ST_EXEC;
      ST_EXEC:   state_d = ST_WB;
      default:   state_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_FETCH;
    else state_q <= state_d;
  end

  always_comb begin
    ir_load     = (state_q == ST_FWAIT);
    pc_inc      = (state_q == ST_INCPC);
    lat_load    = (state_q == ST_OPWAIT);
    alu_load    = (state_q == ST_EXEC);
    retire      = (state_q == ST_WB);
    rf_we       = retire && is_rd;
    mem_we      = retire && is_st;
    use_op_addr = (state_q == ST_OPADDR) || (state_q == ST_OPWAIT) ||
                  (state_q == ST_EXEC) || (state_q == ST_WB);
  end

endmodule

// File: rtl/mcpu16_core.sv
module mcpu16_core
  import mcpu16_pkg::*;
#(
  parameter int              ADDR_W     = 10,
  parameter int              DATA_W     = 16,
  parameter int              NREG       = 4,
  parameter logic [ADDR_W-1:0] START_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              retire
);

  localparam int SEL_W = $clog2(NREG);

  logic [ADDR_W-1:0] pc_q;
  logic [DATA_W-1:0] ir_q;
  logic [OPC_W-1:0]  ir_opc;
  logic [SEL_W-1:0]  ir_sel;
  logic [ADDR_W-1:0] ir_adr;

  logic    ir_load;
  logic    pc_inc;
  logic    lat_load;
  logic    alu_load;
  logic    rf_we;
  logic    use_op_addr;
  alu_op_t alu_op;

  logic [DATA_W-1:0] rf_rdata;
  logic [DATA_W-1:0] alu_out;

  assign ir_opc = ir_q[DATA_W-1 -: OPC_W];
  assign ir_sel = ir_q[ADDR_W +: SEL_W];
  assign ir_adr = ir_q[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= START_ADDR;
    else if (pc_inc) pc_q <= pc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ir_q <= '0;
    else if (ir_load) ir_q <= mem_rdata;
  end

  mcpu16_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .opcode      (ir_opc),
    .ir_load     (ir_load),
    .pc_inc      (pc_inc),
    .lat_load    (lat_load),
    .alu_load    (alu_load),
    .rf_we       (rf_we),
    .mem_we      (mem_we),
    .use_op_addr (use_op_addr),
    .retire      (retire),
    .alu_op      (alu_op)
  );

  mcpu16_regfile #(
    .NREG   (NREG),
    .DATA_W (DATA_W),
    .SEL_W  (SEL_W)
  ) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (rf_we),
    .wsel  (ir_sel),
    .wdata (alu_out),
    .rsel  (ir_sel),
    .rdata (rf_rdata)
  );

  mcpu16_alu #(
    .DATA_W (DATA_W)
  ) u_alu (
    .clk      (clk),
    .rst_n    (rst_n),
    .lat_load (lat_load),
    .a_in     (rf_rdata),
    .b_in     (mem_rdata),
    .alu_load (alu_load),
    .op       (alu_op),
    .out_q    (alu_out)
  );

  assign mem_addr  = use_op_addr ? ir_adr : pc_q;
  assign mem_wdata = rf_rdata;

endmodule

// File: rtl/mcpu16_chk.sv
module mcpu16_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] pc,
  input logic              retire,
  input logic              mem_we,
  input logic              rf_we,
  input logic              ir_load
);

  logic [2:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gap_q <= 3'd7;
    else if (retire) gap_q <= 3'd0;
    else if (gap_q != 3'd7) gap_q <= gap_q + 3'd1;
  end

  assert_store_at_retire_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> retire);

  assert_regwrite_at_retire_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> retire);

  assert_retire_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    retire |=> !retire);

  assert_min_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    retire |-> (gap_q >= 3'd4));

  assert_pc_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pc != $past(pc)) |-> (pc == ADDR_W'($past(pc) + 1'b1)));

  assert_pc_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    retire |-> $stable(pc));

  assert_fetch_not_retire_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ir_load |-> !retire);

endmodule

bind mcpu16_core mcpu16_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .pc      (pc_q),
  .retire  (retire),
  .mem_we  (mem_we),
  .rf_we   (rf_we),
  .ir_load (ir_load)
);

// File: tb/tb_mcpu16_core.sv
module tb_mcpu16_core;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_we;
  logic [15:0] mem_rdata;
  logic        retire;

  always #10 clk = ~clk;

  mcpu16_core #(.START_ADDR(10'h080)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .mem_rdata (mem_rdata),
    .retire    (retire)
  );

  logic [15:0] mem  [1024];
  logic [15:0] rmem [1024];
  logic [15:0] rreg [4];
  logic [9:0]  rpc;

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  int total = 0;
  int fails = 0;
  int cyc = 0;
  int nret = 0;
  int test_id = 0;
  bit run_en = 1'b0;
  bit prev_ret = 1'b0;
  bit saw_083 = 1'b0;
  bit saw_wrap = 1'b0;

  logic [9:0]  q_addr [$];
  bit          q_we   [$];
  logic [15:0] q_wd   [$];
  bit          q_ret  [$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic push(input logic [9:0] a, input bit we, input logic [15:0] wd, input bit rt);
    q_addr.push_back(a);
    q_we.push_back(we);
    q_wd.push_back(wd);
    q_ret.push_back(rt);
  endtask

  task automatic build();
    logic [15:0] w;
    logic [3:0]  op;
    logic [1:0]  r;
    logic [9:0]  a;
    logic [9:0]  pc1;
    w   = rmem[rpc];
    op  = w[15:12];
    r   = w[11:10];
    a   = w[9:0];
    pc1 = rpc + 10'd1;
    push(rpc, 1'b0, 16'h0, 1'b0);
    push(rpc, 1'b0, 16'h0, 1'b0);
    push(rpc, 1'b0, 16'h0, 1'b0);
    push(pc1, 1'b0, 16'h0, 1'b0);
    if (op == 4'd1 || op == 4'd3 || op == 4'd4) begin
      push(a, 1'b0, 16'h0, 1'b0);
      push(a, 1'b0, 16'h0, 1'b0);
      push(a, 1'b0, 16'h0, 1'b0);
      push(a, 1'b0, 16'h0, 1'b1);
      if (op == 4'd1) rreg[r] = rmem[a];
      else if (op == 4'd3) rreg[r] = rreg[r] + rmem[a];
      else rreg[r] = rreg[r] - rmem[a];
    end else if (op == 4'd2) begin
      push(a, 1'b1, rreg[r], 1'b1);
      rmem[a] = rreg[r];
    end else begin
      push(a, 1'b0, 16'h0, 1'b1);
    end
    rpc = pc1;
  endtask

  // Reference comparison on every clock, sampled 1 ns after the falling edge.
  always @(negedge clk) begin
    #1;
    if (run_en) begin
      logic [9:0]  ea;
      bit          ew;
      logic [15:0] ed;
      bit          er;
      if (q_addr.size() == 0) build();
      ea = q_addr.pop_front();
      ew = q_we.pop_front();
      ed = q_wd.pop_front();
      er = q_ret.pop_front();
      chk(mem_addr === ea, "R3 address sequence", 32'(mem_addr), 32'(ea));
      chk(mem_we === ew, "R5 write enable", 32'(mem_we), 32'(ew));
      if (ew) chk(mem_wdata === ed, "R5 store data", 32'(mem_wdata), 32'(ed));
      chk(retire === er, "R10 retire strobe", 32'(retire), 32'(er));
      if (prev_ret && nret == 3 && test_id == 1 && mem_addr == 10'h083) saw_083 = 1'b1;
      if (prev_ret && test_id == 3 && mem_addr == 10'h000) saw_wrap = 1'b1;
      prev_ret = retire;
      if (retire) nret++;
    end
  end

  task automatic put(input int a, input logic [15:0] v);
    mem[a]  = v;
    rmem[a] = v;
  endtask

  task automatic start_reset();
    rst_n  = 1'b0;
    run_en = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 1024; i++) begin
      mem[i]  = 16'h0000;
      rmem[i] = 16'h0000;
    end
    for (int i = 0; i < 4; i++) rreg[i] = 16'h0000;
    rpc = 10'h080;
    q_addr.delete();
    q_we.delete();
    q_wd.delete();
    q_ret.delete();
    nret = 0;
    prev_ret = 1'b0;
  endtask

  task automatic release_reset();
    @(negedge clk);
    #1;
    chk(mem_addr == 10'h080, "R1 reset address", 32'(mem_addr), 32'h080);
    chk(mem_we == 1'b0, "R1 reset write enable", 32'(mem_we), 0);
    chk(retire == 1'b0, "R1 reset retire", 32'(retire), 0);
    @(negedge clk);
    rst_n  = 1'b1;
    run_en = 1'b1;
  endtask

  task automatic run_until(input int n);
    while (nret < n) begin
      @(negedge clk);
      #2;
    end
    @(negedge clk);
    #2;
    run_en = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=%0d expected<=150000", cyc);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    // Test 1: three-instruction program; R2 holds 000F; clear registers stored.
    test_id = 1;
    start_reset();
    put(10'h080, 16'h1A01);
    put(10'h081, 16'h3A02);
    put(10'h082, 16'h2A00);
    put(10'h083, 16'h2E10); // store R3 -> 210
    put(10'h084, 16'h2211); // store R0 -> 211
    put(10'h200, 16'h0000);
    put(10'h201, 16'h0009);
    put(10'h202, 16'h0006);
    put(10'h210, 16'hAAAA);
    put(10'h211, 16'hAAAA);
    release_reset();
    run_until(5);
    chk(mem[10'h200] == 16'h000F, "R6 add result stored", 32'(mem[10'h200]), 32'h000F);
    chk(saw_083, "R9 fetch at 083 after program", 32'(saw_083), 1);
    chk(mem[10'h210] == 16'h0000, "R1 R3 cleared by reset", 32'(mem[10'h210]), 0);
    chk(mem[10'h211] == 16'h0000, "R1 R0 cleared by reset", 32'(mem[10'h211]), 0);

    // Test 2: all registers, wrap, undefined opcodes, self-modifying store.
    test_id = 2;
    start_reset();
    put(10'h080, 16'h1300);
    put(10'h081, 16'h1701);
    put(10'h082, 16'h1B02);
    put(10'h083, 16'h1F03);
    put(10'h084, 16'h3704);
    put(10'h085, 16'h4B05);
    put(10'h086, 16'hF320);
    put(10'h087, 16'h5320);
    put(10'h088, 16'h0320);
    put(10'h089, 16'h2310);
    put(10'h08A, 16'h2711);
    put(10'h08B, 16'h2B12);
    put(10'h08C, 16'h2F13);
    put(10'h08D, 16'h208E);
    put(10'h08E, 16'h0000);
    put(10'h300, 16'h2F30);
    put(10'h301, 16'h7FFF);
    put(10'h302, 16'h0000);
    put(10'h303, 16'hABCD);
    put(10'h304, 16'h0001);
    put(10'h305, 16'h0001);
    put(10'h320, 16'h5555);
    release_reset();
    run_until(15);
    chk(mem[10'h310] == 16'h2F30, "R4 R12 load into R0", 32'(mem[10'h310]), 32'h2F30);
    chk(mem[10'h311] == 16'h8000, "R6 add wraps", 32'(mem[10'h311]), 32'h8000);
    chk(mem[10'h312] == 16'hFFFF, "R7 subtract wraps", 32'(mem[10'h312]), 32'hFFFF);
    chk(mem[10'h313] == 16'hABCD, "R12 R3 independent", 32'(mem[10'h313]), 32'hABCD);
    chk(mem[10'h320] == 16'h5555, "R8 undefined opcode leaves memory", 32'(mem[10'h320]), 32'h5555);
    chk(mem[10'h08E] == 16'h2F30, "R5 store over next word", 32'(mem[10'h08E]), 32'h2F30);
    chk(mem[10'h330] == 16'hABCD, "R11 rewritten word executed", 32'(mem[10'h330]), 32'hABCD);

    // Test 3: PC wraps from 3FF to 000.
    test_id = 3;
    start_reset();
    put(10'h3FE, 16'h17F0);
    put(10'h3FF, 16'h37F0);
    put(10'h000, 16'h27F1);
    put(10'h3F0, 16'h0111);
    release_reset();
    run_until(897);
    chk(saw_wrap, "R9 fetch at 000 after 3FF", 32'(saw_wrap), 1);
    chk(mem[10'h3F1] == 16'h0222, "R9 program across wrap", 32'(mem[10'h3F1]), 32'h0222);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule